// File: doc/BRIEF.md
# Arbitration Acceleration Enable Control

This block sits in a serial-bus physical layer. It produces the one flag that allows or blocks the arbitration speed-ups: fly-by concatenation of isochronous packets, appending fair or priority packets to acknowledges, and shortened arbitration after an acknowledge. The flag is a static configuration bit combined with a runtime override that the link layer can clear and set at any time. The speed-ups themselves are built elsewhere and read only the flag.

The link clears the override shortly before a cycle-start message is due, which it learns from a rollover of its cycle counter. It sets the override again once a cycle-start message arrives. The link can also set or clear the override directly with an acceleration-control request. A bus reset or an isochronous bus request always restores the override. When a restoring event and a clearing event arrive in the same cycle, the restoring event wins.

Top module: `accel_enable_ctrl`

## Requirements
- R1: `accelActive` is high exactly when `cfgAccelEn` is high and the override is enabled. Lowering `cfgAccelEn` drops `accelActive` in the same cycle, with no clock edge needed.
- R2: After reset the override is enabled, so `accelActive` follows `cfgAccelEn`.
- R3: A cycle with `linkReqValid` high sets the override to the value of `linkReqEnable` (1 enables, 0 disables). The new value appears on `accelActive` right after the next clock edge.
- R4: `busReset` enables the override at the next clock edge, whatever the value of `cfgAccelEn`.
- R5: `isoReq` enables the override at the next clock edge, whatever the value of `cfgAccelEn`.
- R6: `cycleRollover` disables the override at the next clock edge.
- R7: `cycleStartRx` enables the override at the next clock edge.
- R8: If any enabling event (R3 enable, R4, R5, R7) occurs in the same cycle as any disabling event (R3 disable, R6), the override ends up enabled.
- R9: In a cycle with no event, the override keeps its value. Changing `cfgAccelEn` never changes the override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAccelEn | input | 1 | Configuration enable for acceleration |
| linkReqValid | input | 1 | Link acceleration-control request strobe |
| linkReqEnable | input | 1 | Requested override value (1 enable, 0 disable) |
| busReset | input | 1 | Bus reset event |
| isoReq | input | 1 | Isochronous bus request event |
| cycleRollover | input | 1 | Link cycle counter rollover event |
| cycleStartRx | input | 1 | Cycle-start message received event |
| accelActive | output | 1 | Effective acceleration enable |

## Verification
All of the block's state is the one override bit, and it is visible at `accelActive` whenever `cfgAccelEn` is high. A wrong override value therefore shows up the first cycle after the event that set it, as a speed-up left on across a cycle start or left off after a bus reset. With the configuration bit low, a wrong override stays hidden until the bit rises. For that reason the bench raises `cfgAccelEn` after every stimulus and reads the override back in that same cycle. The sweep covers all 64 event combinations, from both starting override values, with the configuration bit both high and low.

// File: rtl/accel_pkg.sv
package accel_pkg;

  // Event vector bit positions
  localparam int EVT_W          = 6;
  localparam int EV_LINK_ON     = 0;
  localparam int EV_LINK_OFF    = 1;
  localparam int EV_BUS_RESET   = 2;
  localparam int EV_ISO_REQ     = 3;
  localparam int EV_ROLLOVER    = 4;
  localparam int EV_CYCLE_START = 5;

  // Events that enable the override
  localparam logic [EVT_W-1:0] RESTORE_MASK =
      (EVT_W'(1) << EV_LINK_ON)   | (EVT_W'(1) << EV_BUS_RESET) |
      (EVT_W'(1) << EV_ISO_REQ)   | (EVT_W'(1) << EV_CYCLE_START);

  // Events that disable the override
  localparam logic [EVT_W-1:0] DROP_MASK =
      (EVT_W'(1) << EV_LINK_OFF)  | (EVT_W'(1) << EV_ROLLOVER);

  typedef struct packed {
    logic setOverride;
    logic clrOverride;
  } ovrStrobe_t;

endpackage

// File: rtl/accel_ctrl.sv
module accel_ctrl
  import accel_pkg::*;
(
  input  logic             linkReqValid,
  input  logic             linkReqEnable,
  input  logic             busReset,
  input  logic             isoReq,
  input  logic             cycleRollover,
  input  logic             cycleStartRx,
  output ovrStrobe_t       strobes
);

  logic [EVT_W-1:0] evtVec;
  logic [EVT_W-1:0] restoreHits;
  logic [EVT_W-1:0] dropHits;
  logic             anyRestore;
  logic             anyDrop;

  always_comb begin
    evtVec                 = '0;
    evtVec[EV_LINK_ON]     = linkReqValid & linkReqEnable;
    evtVec[EV_LINK_OFF]    = linkReqValid & ~linkReqEnable;
    evtVec[EV_BUS_RESET]   = busReset;
    evtVec[EV_ISO_REQ]     = isoReq;
    evtVec[EV_ROLLOVER]    = cycleRollover;
    evtVec[EV_CYCLE_START] = cycleStartRx;
  end

  for (genvar i = 0; i < EVT_W; i++) begin : g_classify
    assign restoreHits[i] = evtVec[i] & RESTORE_MASK[i];
    assign dropHits[i]    = evtVec[i] & DROP_MASK[i];
  end

  assign anyRestore = |restoreHits;
  assign anyDrop    = |dropHits;

  // Enabling events win over disabling events in the same cycle
  always_comb begin
    strobes.setOverride = anyRestore;
    strobes.clrOverride = anyDrop & ~anyRestore;
  end

endmodule

// File: rtl/accel_dp.sv
module accel_dp
  import accel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgAccelEn,
  input  ovrStrobe_t strobes,
  output logic       accelActive
);

  logic overrideQ;

  always_ff @(posedge clk) begin
    if (!rstN)                    overrideQ <= 1'b1;
    else if (strobes.setOverride) overrideQ <= 1'b1;
    else if (strobes.clrOverride) overrideQ <= 1'b0;
  end

  assign accelActive = cfgAccelEn & overrideQ;

endmodule

// File: rtl/accel_enable_ctrl.sv
module accel_enable_ctrl
  import accel_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic cfgAccelEn,
  input  logic linkReqValid,
  input  logic linkReqEnable,
  input  logic busReset,
  input  logic isoReq,
  input  logic cycleRollover,
  input  logic cycleStartRx,
  output logic accelActive
);

  ovrStrobe_t strobes;

  accel_ctrl u_ctrl (
    .linkReqValid  (linkReqValid),
    .linkReqEnable (linkReqEnable),
    .busReset      (busReset),
    .isoReq        (isoReq),
    .cycleRollover (cycleRollover),
    .cycleStartRx  (cycleStartRx),
    .strobes       (strobes)
  );

  accel_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cfgAccelEn  (cfgAccelEn),
    .strobes     (strobes),
    .accelActive (accelActive)
  );

endmodule

// File: rtl/accel_enable_chk.sv
module accel_enable_chk (
  input logic clk,
  input logic rstN,
  input logic cfgAccelEn,
  input logic linkReqValid,
  input logic linkReqEnable,
  input logic busReset,
  input logic isoReq,
  input logic cycleRollover,
  input logic cycleStartRx,
  input logic accelActive
);

  logic anyOn;
  logic anyOff;
  assign anyOn  = busReset | isoReq | cycleStartRx | (linkReqValid & linkReqEnable);
  assign anyOff = cycleRollover | (linkReqValid & ~linkReqEnable);

  // R1: configuration bit gates the output
  a_r1_cfg_gate: assert property (@(posedge clk) disable iff (!rstN)
    !cfgAccelEn |-> !accelActive);

  // R4 R5 R7 R8: any enabling event leaves the output equal to the config bit
  a_r8_restore_wins: assert property (@(posedge clk) disable iff (!rstN)
    anyOn |=> (accelActive == cfgAccelEn));

  // R6: a disabling event alone clears the output
  a_r6_drop: assert property (@(posedge clk) disable iff (!rstN)
    (anyOff && !anyOn) |=> !accelActive);

  // R9: no event and config held high keeps the output
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!anyOn && !anyOff && cfgAccelEn) |=> (!cfgAccelEn || accelActive == $past(accelActive)));

endmodule

bind accel_enable_ctrl accel_enable_chk u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .cfgAccelEn    (cfgAccelEn),
  .linkReqValid  (linkReqValid),
  .linkReqEnable (linkReqEnable),
  .busReset      (busReset),
  .isoReq        (isoReq),
  .cycleRollover (cycleRollover),
  .cycleStartRx  (cycleStartRx),
  .accelActive   (accelActive)
);

// File: tb/sim_accel_enable_ctrl.sv
`timescale 1ns/1ps
module sim_accel_enable_ctrl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgAccelEn = 1'b0;
  logic linkReqValid = 1'b0;
  logic linkReqEnable = 1'b0;
  logic busReset = 1'b0;
  logic isoReq = 1'b0;
  logic cycleRollover = 1'b0;
  logic cycleStartRx = 1'b0;
  logic accelActive;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  accel_enable_ctrl u0 (
    .clk(clk), .rstN(rstN), .cfgAccelEn(cfgAccelEn),
    .linkReqValid(linkReqValid), .linkReqEnable(linkReqEnable),
    .busReset(busReset), .isoReq(isoReq), .cycleRollover(cycleRollover),
    .cycleStartRx(cycleStartRx), .accelActive(accelActive)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: accelActive=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clearEvents();
    linkReqValid = 0; linkReqEnable = 0; busReset = 0;
    isoReq = 0; cycleRollover = 0; cycleStartRx = 0;
  endtask

  // Bits: 0 valid, 1 enable, 2 busReset, 3 isoReq, 4 rollover, 5 cycleStart
  task automatic driveCombo(input logic [5:0] c);
    linkReqValid = c[0]; linkReqEnable = c[1]; busReset = c[2];
    isoReq = c[3]; cycleRollover = c[4]; cycleStartRx = c[5];
  endtask

  function automatic string tagFor(input logic [5:0] c);
    logic on, off;
    on  = c[2] | c[3] | c[5] | (c[0] & c[1]);
    off = c[4] | (c[0] & ~c[1]);
    if (on && off) return "R8";
    if (c[2]) return "R4";
    if (c[3]) return "R5";
    if (c[5]) return "R7";
    if (c[4]) return "R6";
    if (c[0]) return "R3";
    return "R9";
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: accelActive=%0b expected completion", accelActive);
    if (!finished) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1;
    cfgAccelEn = 1;
    #1 check(accelActive, 1'b1, "R2 reset enables override");
    cfgAccelEn = 0;
    #1 check(accelActive, 1'b0, "R1 config low gates immediately");

    for (int prev = 0; prev < 2; prev++) begin
      for (int cfg = 0; cfg < 2; cfg++) begin
        for (int combo = 0; combo < 64; combo++) begin
          logic [5:0] c;
          logic on, off, nxt;
          c = 6'(combo);
          // set starting override through link request
          @(negedge clk);
          cfgAccelEn = 1; clearEvents();
          linkReqValid = 1; linkReqEnable = prev[0];
          @(negedge clk);
          clearEvents();
          check(accelActive, prev[0], "R3 preset override");
          // apply event combination
          cfgAccelEn = cfg[0];
          driveCombo(c);
          on  = c[2] | c[3] | c[5] | (c[0] & c[1]);
          off = c[4] | (c[0] & ~c[1]);
          nxt = on ? 1'b1 : (off ? 1'b0 : prev[0]);
          @(negedge clk);
          check(accelActive, cfg[0] & nxt, tagFor(c));
          clearEvents();
          // expose override with config high (R9: config never alters it)
          cfgAccelEn = 1;
          #1 check(accelActive, nxt, cfg ? tagFor(c) : "R9 override readback");
        end
      end
    end

    // R1: toggling config with no events
    @(negedge clk);
    cfgAccelEn = 1; linkReqValid = 1; linkReqEnable = 1;
    @(negedge clk); clearEvents();
    cfgAccelEn = 0;
    #1 check(accelActive, 1'b0, "R1 config low");
    cfgAccelEn = 1;
    #1 check(accelActive, 1'b1, "R1 config high");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule